// File: doc/BRIEF.md
# Content-Addressable Match Array

This block is a small content-addressable memory. It keeps a fixed set of key entries, each loaded by index, and on request compares one search key against all of them at once. The outcome comes back one clock later as two separate flags (exactly one hit, more than one hit) and the index of the lowest-numbered entry that matched.

Entries carry no valid bit. After reset every entry holds zero, and zero entries take part in searches like any other. A request cycle is either a load (request and write both high) or a search (request high, write low). A load performs no search. The stored key is visible to a search issued in the very next cycle.

Top module: `cam_match_array`

## Requirements
- R1: While reset is asserted and in the first cycle after it, hit_one and hit_many are 0 and hit_idx is 0. All entries hold the value zero.
- R2: A cycle with req_en low changes no entry, even if req_wr is high. The result registered from that cycle has hit_one=0, hit_many=0 and hit_idx=0.
- R3: A cycle with req_en=1 and req_wr=1 stores req_key into entry req_idx. The result registered from that cycle has hit_one=0 and hit_many=0, because no search runs.
- R4: A search whose key equals exactly one entry gives hit_one=1, hit_many=0 and hit_idx equal to that entry's index.
- R5: A search whose key equals two or more entries gives hit_many=1 and hit_one=0. The two flags are never high together.
- R6: When several entries match, hit_idx is the lowest matching index.
- R7: A search whose key equals no entry gives hit_one=0, hit_many=0 and hit_idx=0.
- R8: A search issued in the cycle right after a load sees the newly stored value in that entry.
- R9: Entries that still hold their reset value take part in searches. Searching for zero right after reset therefore gives hit_many=1 and hit_idx=0.
- R10: Each result is registered. It appears on the outputs after the rising edge that samples the request, and it holds until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_en | input | 1 | Request valid for this cycle |
| req_wr | input | 1 | With req_en: load instead of search |
| req_idx | input | IDX_W | Entry index for a load |
| req_key | input | KEY_W | Key to store or to search for |
| hit_one | output | 1 | Registered: exactly one entry matched |
| hit_many | output | 1 | Registered: two or more entries matched |
| hit_idx | output | IDX_W | Registered: lowest matching index, 0 on a miss |

## Verification
Two functions meet in time here. A load and a search never share a cycle, so the first question is whether a load cycle suppresses the search result. The second is whether a load and a search in back-to-back cycles interact correctly. The bench issues loads with keys that already match stored entries and expects both flags to stay low. It also follows loads at once with searches for the just-written key, and judges every result against a reference copy of the array one cycle after the request.

// File: rtl/cam_pkg.sv
package cam_pkg;

   typedef enum logic [1:0] {
      HITS_NONE = 2'd0,
      HITS_ONE  = 2'd1,
      HITS_MANY = 2'd2
   } hit_class_e;

endpackage

// File: rtl/cam_entry_store.sv
module cam_entry_store #(
   parameter int ENTRIES = 4,
   parameter int KEY_W   = 4,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            load,
   input  logic [IDX_W-1:0]                load_idx,
   input  logic [KEY_W-1:0]                load_key,
   output logic [ENTRIES-1:0][KEY_W-1:0]   entries
);

   for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            entries[g] <= '0;
         else if (load && (load_idx == IDX_W'(g)))
            entries[g] <= load_key;
      end
   end

endmodule

// File: rtl/cam_compare.sv
module cam_compare #(
   parameter int ENTRIES = 4,
   parameter int KEY_W   = 4
) (
   input  logic                            search,
   input  logic [KEY_W-1:0]                key,
   input  logic [ENTRIES-1:0][KEY_W-1:0]   entries,
   output logic [ENTRIES-1:0]              hits
);

   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign hits[g] = search && (entries[g] == key);
   end

endmodule

// File: rtl/cam_resolve.sv
module cam_resolve
   import cam_pkg::*;
#(
   parameter int ENTRIES = 4,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic [ENTRIES-1:0] hits,
   output hit_class_e         hclass,
   output logic [IDX_W-1:0]   first_idx
);

   logic many;
   logic [ENTRIES-1:0] rest;

   // lowest-index priority encoder: scan down so the lowest set bit wins
   always_comb begin
      first_idx = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (hits[i]) first_idx = IDX_W'(i);
      end
   end

   // clearing the lowest set bit leaves something only if two or more were set
   assign rest = hits & (hits - ENTRIES'(1));
   assign many = |rest;

   always_comb begin
      if (many)       hclass = HITS_MANY;
      else if (|hits) hclass = HITS_ONE;
      else            hclass = HITS_NONE;
   end

endmodule

// File: rtl/cam_match_array.sv
module cam_match_array
   import cam_pkg::*;
#(
   parameter int ENTRIES = 4,
   parameter int KEY_W   = 4,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_en,
   input  logic             req_wr,
   input  logic [IDX_W-1:0] req_idx,
   input  logic [KEY_W-1:0] req_key,
   output logic             hit_one,
   output logic             hit_many,
   output logic [IDX_W-1:0] hit_idx
);

   if (ENTRIES < 2) begin : g_bad_entries
      $error("cam_match_array: ENTRIES must be at least 2");
   end
   if (KEY_W < 1) begin : g_bad_key
      $error("cam_match_array: KEY_W must be at least 1");
   end

   logic                          do_load;
   logic                          do_search;
   logic [ENTRIES-1:0][KEY_W-1:0] entries;
   logic [ENTRIES-1:0]            hit_vec;
   hit_class_e                    hclass;
   logic [IDX_W-1:0]              first_idx;

   assign do_load   = req_en && req_wr;
   assign do_search = req_en && !req_wr;

   cam_entry_store #(.ENTRIES(ENTRIES), .KEY_W(KEY_W)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (do_load),
      .load_idx (req_idx),
      .load_key (req_key),
      .entries  (entries)
   );

   cam_compare #(.ENTRIES(ENTRIES), .KEY_W(KEY_W)) u_cmp (
      .search  (do_search),
      .key     (req_key),
      .entries (entries),
      .hits    (hit_vec)
   );

   cam_resolve #(.ENTRIES(ENTRIES)) u_res (
      .hits      (hit_vec),
      .hclass    (hclass),
      .first_idx (first_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit_one  <= 1'b0;
         hit_many <= 1'b0;
         hit_idx  <= '0;
      end else begin
         hit_one  <= (hclass == HITS_ONE);
         hit_many <= (hclass == HITS_MANY);
         hit_idx  <= first_idx;
      end
   end

   // R5
   flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(hit_one && hit_many));

   // R2
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_en |=> (!hit_one && !hit_many && hit_idx == '0));

   // R3
   load_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_en && req_wr) |=> (!hit_one && !hit_many));

   // R7
   miss_index_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit_one && !hit_many) |-> (hit_idx == '0));

   // R6
   lowest_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|hit_vec) |=> ((($past(hit_vec) >> hit_idx) & ENTRIES'(1)) == ENTRIES'(1)
                      && ($past(hit_vec) & ((ENTRIES'(1) << hit_idx) - ENTRIES'(1))) == '0));

   // R8
   load_then_search_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_en && !req_wr && $past(req_en && req_wr) && req_key == $past(req_key))
      |=> (hit_one || hit_many));

endmodule

// File: tb/sim_cam_match_array.sv
`timescale 1ns/1ps
module sim_cam_match_array;

   localparam int ENTRIES = 4;
   localparam int KEY_W   = 4;
   localparam int IDX_W   = $clog2(ENTRIES);

   typedef struct {
      logic             one;
      logic             many;
      logic [IDX_W-1:0] idx;
      string            tag;
   } exp_t;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             req_en = 1'b0;
   logic             req_wr = 1'b0;
   logic [IDX_W-1:0] req_idx = '0;
   logic [KEY_W-1:0] req_key = '0;
   logic             hit_one;
   logic             hit_many;
   logic [IDX_W-1:0] hit_idx;

   int checks = 0;
   int failures = 0;
   exp_t q[$];
   logic [KEY_W-1:0] model [ENTRIES];

   always #2.5 clk = ~clk;

   cam_match_array #(.ENTRIES(ENTRIES), .KEY_W(KEY_W)) u0 (
      .clk(clk), .rst_n(rst_n), .req_en(req_en), .req_wr(req_wr),
      .req_idx(req_idx), .req_key(req_key),
      .hit_one(hit_one), .hit_many(hit_many), .hit_idx(hit_idx)
   );

   task automatic compare(input exp_t e);
      checks++;
      if (hit_one !== e.one || hit_many !== e.many || hit_idx !== e.idx) begin
         failures++;
         $display("FAIL %s: got one=%b many=%b idx=%0d, expected one=%b many=%b idx=%0d",
                  e.tag, hit_one, hit_many, hit_idx, e.one, e.many, e.idx);
      end
   endtask

   // driver: computes the expected result from the reference array, then drives
   task automatic op(input logic en, input logic wr, input int idx,
                     input logic [KEY_W-1:0] key, input string tag);
      exp_t e;
      int cnt;
      e.one = 0; e.many = 0; e.idx = '0; e.tag = tag;
      @(negedge clk);
      if (en && !wr) begin
         cnt = 0;
         for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (model[i] == key) begin cnt++; e.idx = IDX_W'(i); end
         end
         if (cnt == 0) e.idx = '0;
         e.one  = (cnt == 1);
         e.many = (cnt > 1);
      end
      if (en && wr) model[idx] = key;
      req_en = en; req_wr = wr; req_idx = IDX_W'(idx); req_key = key;
      q.push_back(e);
   endtask

   // monitor: one result per request, sampled 1 ns after the capturing edge (R10)
   always @(posedge clk) begin
      #1;
      if (q.size() > 0) compare(q.pop_front());
   end

   initial begin
      #1000000;
      failures++;
      checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      exp_t r;
      for (int i = 0; i < ENTRIES; i++) model[i] = '0;
      repeat (3) @(posedge clk);
      #1;
      r.one = 0; r.many = 0; r.idx = '0; r.tag = "R1 reset outputs";
      compare(r);
      @(negedge clk);
      rst_n = 1'b1;
      op(0, 0, 0, 4'd0, "R2 idle with zero key");
      op(1, 0, 0, 4'd0, "R9 zero key hits reset entries, R6 lowest index");
      op(1, 0, 0, 4'd1, "R7 miss after reset");
      op(1, 1, 0, 4'd0, "R3 load with key matching all entries");
      op(1, 1, 0, 4'd4, "R3 load entry 0");
      op(1, 0, 0, 4'd4, "R4 single hit entry 0");
      op(1, 0, 0, 4'd5, "R7 miss");
      op(1, 1, 1, 4'd5, "R3 load entry 1");
      op(1, 1, 2, 4'd5, "R3 load entry 2");
      op(1, 0, 0, 4'd5, "R5 R6 two hits report index 1");
      op(1, 1, 0, 4'd7, "R3 load entry 0 again");
      op(1, 0, 0, 4'd7, "R8 search right after load");
      op(0, 1, 3, 4'd9, "R2 write with enable low");
      op(1, 0, 0, 4'd9, "R2 ignored write left no entry");
      op(1, 0, 0, 4'd0, "R2 R4 entry 3 still zero");
      for (int i = 0; i < ENTRIES; i++) op(1, 1, i, KEY_W'(i + 8), "R3 sweep load");
      for (int i = ENTRIES - 1; i >= 0; i--) op(1, 0, 0, KEY_W'(i + 8), "R4 sweep single hit");
      for (int i = 0; i < ENTRIES; i++) begin
         op(1, 1, i, 4'd3, "R3 fill with 3");
         op(1, 0, 0, 4'd3, "R8 R5 R6 grow matching set");
      end
      op(1, 1, 0, 4'd3, "R3 reload entry 0");
      op(1, 0, 0, 4'd2, "R7 miss on full array");
      op(0, 0, 0, 4'd3, "R2 idle after hits");
      @(negedge clk);
      req_en = 1'b0;
      repeat (2) @(posedge clk);
      #2;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule